// File: doc/BRIEF.md
# Dual-Channel Cascadable 8-bit Timer

This block gives a microcontroller two 8-bit timer channels behind a small byte-wide register port. Each channel advances an up-counter from a chosen clock source, which is one of three fixed divisions of the system clock, a synchronised external event input, or an event taken from the other channel. Two compare values per channel are tested against the counter on every count step. The resulting match events clear the counter, drive a compare output pin, and set interrupt flags.

The two channels can be joined in two ways. In the first, channel 0 counts the overflows of channel 1, which forms one 16-bit counter with channel 0 as the high byte. In the second, channel 1 counts the match-A events of channel 0. A match A on channel 0 also issues a single-cycle start pulse for an analog converter. After reset the whole block sits in a stop state. Only the stop register answers until software releases it.

Top module: `dual_timer`

## Requirements
- R1: After reset the block is stopped (stop register at address 0x7, bit 0, reads 1). While it is stopped, the counters do not move, writes to any other address are ignored, and reads of any other address return 0. Writing 0 to bit 0 releases the stop.
- R2: Channel control bits [2:0] select the count source: 0 off, 1 system clock / PRE_LO, 2 system clock / PRE_MID, 3 system clock / PRE_HI, 4 external input, 5 partner channel. A prescaled source advances the counter exactly once per division period.
- R3: Control bits [6:5] select the external edge: 0 rising, 1 falling, 2 both (3 acts as rising). The external input passes a SYNC_STAGES flop synchroniser before edge detection.
- R4: On each count step the counter goes up by one and wraps from 0xFF to 0x00, and that wrap is an overflow event. A match event A or B fires when a step lands the counter on that compare value. A bus write to the counter takes priority over a step. Compare registers reset to 0xFF.
- R5: Control bits [4:3] select the clear source: 0 none, 1 match A, 2 match B, 3 rising edge of the external reset input. With match clear, the step taken while the counter equals the compare value loads 0 instead of incrementing.
- R6: Output-control bits [1:0] (match A) and [3:2] (match B) pick the pin action: 0 hold, 1 drive 0, 2 drive 1, 3 toggle. When both matches occur in one step, only the match-A action applies. Writing output control loads the pin from bit 4.
- R7: Flag register bits [0] match A, [1] match B and [2] overflow are set by their events. A flag bit clears only when 0 is written to it after a read returned it as 1. A new event in the same cycle wins over the clear.
- R8: Each interrupt output is its flag ANDed with the enable bit in the same position of the enable register.
- R9: Every channel-0 match A produces a one-cycle `conv_trig` pulse in the cycle after the step that caused it.
- R10: With channel 0 on source 5 and channel 1 counting, channel 0 advances in the same step in which channel 1 wraps. The two counters then form one 16-bit count with channel 0 as the high byte.
- R11: With channel 1 on source 5, channel 1 advances once for each channel-0 match A.
- R12: Address bit 3 selects the channel, and bits [2:0] select the register: 0 control, 1 counter, 2 compare A, 3 compare B, 4 output control, 5 interrupt enable, 6 flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ext_clk_in | input | 2 | External count inputs, one per channel |
| ext_rst_in | input | 2 | External counter-clear inputs, one per channel |
| tmr_out | output | 2 | Compare output pins |
| irq_match_a | output | 2 | Match-A interrupt per channel |
| irq_match_b | output | 2 | Match-B interrupt per channel |
| irq_ovf | output | 2 | Overflow interrupt per channel |
| conv_trig | output | 1 | Converter start pulse |

## Verification
The bench keeps PRE_LO at 8 and PRE_MID at 64, and it lowers PRE_HI to 512. With that setting all three prescaled periods can be measured directly within a short run. SYNC_STAGES stays at 2. Every external pulse is held for three cycles so that the synchroniser latency never hides an edge. Because the counters are only 8 bits wide, wrap, overflow and 16-bit carry are reached by preloading values near 0xFF instead of by counting from zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BUS_W   = 8;
    localparam int CNT_W   = 8;
    localparam int ADDR_W  = 4;
    localparam int OFF_W   = 3;
    localparam int NUM_CH  = 2;
    localparam int NUM_EVT = 3;

    localparam logic [OFF_W-1:0] OFF_CTRL  = 3'd0;
    localparam logic [OFF_W-1:0] OFF_COUNT = 3'd1;
    localparam logic [OFF_W-1:0] OFF_CMPA  = 3'd2;
    localparam logic [OFF_W-1:0] OFF_CMPB  = 3'd3;
    localparam logic [OFF_W-1:0] OFF_OCTL  = 3'd4;
    localparam logic [OFF_W-1:0] OFF_IEN   = 3'd5;
    localparam logic [OFF_W-1:0] OFF_FLAGS = 3'd6;
    localparam logic [ADDR_W-1:0] ADDR_STOP = 4'h7;

    typedef enum logic [2:0] {
        SRC_OFF     = 3'd0,
        SRC_DIV_LO  = 3'd1,
        SRC_DIV_MID = 3'd2,
        SRC_DIV_HI  = 3'd3,
        SRC_EXT     = 3'd4,
        SRC_CHAIN   = 3'd5
    } clk_src_e;

    typedef enum logic [1:0] {
        CLR_NONE    = 2'd0,
        CLR_MATCH_A = 2'd1,
        CLR_MATCH_B = 2'd2,
        CLR_EXT     = 2'd3
    } clr_sel_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2
    } edge_sel_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    // Packed so that bit 0 = match A, bit 1 = match B, bit 2 = overflow
    typedef struct packed {
        logic ovf;
        logic match_b;
        logic match_a;
    } tmr_evt_t;

    // Packed so that [2:0] = source, [4:3] = clear, [6:5] = edge
    typedef struct packed {
        edge_sel_e edge_sel;
        clr_sel_e  clr;
        clk_src_e  src;
    } ctrl_t;

    function automatic logic edge_hit(edge_sel_e sel, logic now, logic was);
        case (sel)
            EDGE_FALL: return !now && was;
            EDGE_BOTH: return now != was;
            default:   return now && !was;
        endcase
    endfunction

    function automatic logic apply_action(pin_act_e act, logic cur);
        case (act)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return !cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_LO  = 8,
    parameter int PRE_MID = 64,
    parameter int PRE_HI  = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick_lo,
    output logic tick_mid,
    output logic tick_hi
);
    localparam int LO_W  = $clog2(PRE_LO);
    localparam int MID_W = $clog2(PRE_MID);
    localparam int HI_W  = $clog2(PRE_HI);

    logic [HI_W-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) div_cnt <= '0;
        else             div_cnt <= div_cnt + 1'b1;
    end

    assign tick_lo  = run && (&div_cnt[LO_W-1:0]);
    assign tick_mid = run && (&div_cnt[MID_W-1:0]);
    assign tick_hi  = run && (&div_cnt[HI_W-1:0]);

    // R2: the slower strobes always coincide with the faster ones
    assert_div_nested_R2: assert property (@(posedge clk) disable iff (rst)
        tick_hi |-> (tick_mid && tick_lo));

endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic now,
    output logic was
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            was     <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            was     <= shift_q[STAGES-1];
        end
    end

    assign now = shift_q[STAGES-1];

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick_lo,
    input  logic             tick_mid,
    input  logic             tick_hi,
    input  logic             ext_now,
    input  logic             ext_was,
    input  logic             xrst_now,
    input  logic             xrst_was,
    input  logic             chain_tick,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFF_W-1:0] off,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output tmr_evt_t         evt,
    output tmr_evt_t         evt_q,
    output logic             pin,
    output logic [NUM_EVT-1:0] irq
);
    ctrl_t              ctrl;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cmp_a;
    logic [CNT_W-1:0]   cmp_b;
    pin_act_e           act_a;
    pin_act_e           act_b;
    logic [NUM_EVT-1:0] ien;
    logic [NUM_EVT-1:0] flags;
    logic [NUM_EVT-1:0] armed;

    logic               tick;
    logic               clear_now;
    logic               ext_clear;
    logic [CNT_W-1:0]   nxt;
    logic               cnt_wr;
    logic               oc_wr;
    logic               flag_wr;
    logic [NUM_EVT-1:0] evt_bits;

    assign cnt_wr  = wr_en && (off == OFF_COUNT);
    assign oc_wr   = wr_en && (off == OFF_OCTL);
    assign flag_wr = wr_en && (off == OFF_FLAGS);

    // Count source selection
    always_comb begin
        case (ctrl.src)
            SRC_DIV_LO:  tick = tick_lo;
            SRC_DIV_MID: tick = tick_mid;
            SRC_DIV_HI:  tick = tick_hi;
            SRC_EXT:     tick = edge_hit(ctrl.edge_sel, ext_now, ext_was);
            SRC_CHAIN:   tick = chain_tick;
            default:     tick = 1'b0;
        endcase
        tick = tick && run;
    end

    // Next value and events
    always_comb begin
        case (ctrl.clr)
            CLR_MATCH_A: clear_now = (cnt == cmp_a);
            CLR_MATCH_B: clear_now = (cnt == cmp_b);
            default:     clear_now = 1'b0;
        endcase
        nxt         = clear_now ? '0 : cnt + 1'b1;
        evt.match_a = tick && (nxt == cmp_a);
        evt.match_b = tick && (nxt == cmp_b);
        evt.ovf     = tick && !clear_now && (&cnt);
    end

    assign ext_clear = run && (ctrl.clr == CLR_EXT) && xrst_now && !xrst_was;
    assign evt_bits  = evt;

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            cmp_a <= '1;
            cmp_b <= '1;
            act_a <= ACT_HOLD;
            act_b <= ACT_HOLD;
            ien   <= '0;
        end else if (wr_en) begin
            case (off)
                OFF_CTRL: ctrl  <= ctrl_t'(wdata[6:0]);
                OFF_CMPA: cmp_a <= wdata[CNT_W-1:0];
                OFF_CMPB: cmp_b <= wdata[CNT_W-1:0];
                OFF_OCTL: begin
                    act_a <= pin_act_e'(wdata[1:0]);
                    act_b <= pin_act_e'(wdata[3:2]);
                end
                OFF_IEN:  ien   <= wdata[NUM_EVT-1:0];
                default: ;
            endcase
        end
    end

    // Counter
    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (cnt_wr)    cnt <= wdata[CNT_W-1:0];
        else if (ext_clear) cnt <= '0;
        else if (tick)      cnt <= nxt;
    end

    // Compare output pin, match A wins
    always_ff @(posedge clk) begin
        if (rst)              pin <= 1'b0;
        else if (oc_wr)       pin <= wdata[4];
        else if (evt.match_a) pin <= apply_action(act_a, pin);
        else if (evt.match_b) pin <= apply_action(act_b, pin);
    end

    // Flags with read-then-write-zero clearing
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            armed <= '0;
        end else begin
            for (int i = 0; i < NUM_EVT; i++) begin
                if (evt_bits[i]) begin
                    flags[i] <= 1'b1;
                end else if (flag_wr && armed[i] && !wdata[i]) begin
                    flags[i] <= 1'b0;
                    armed[i] <= 1'b0;
                end else if (rd_en && (off == OFF_FLAGS) && flags[i]) begin
                    armed[i] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt;
    end

    assign irq = flags & ien;

    always_comb begin
        case (off)
            OFF_CTRL:  rdata = {1'b0, ctrl};
            OFF_COUNT: rdata = cnt;
            OFF_CMPA:  rdata = cmp_a;
            OFF_CMPB:  rdata = cmp_b;
            OFF_OCTL:  rdata = {3'b000, pin, act_b, act_a};
            OFF_IEN:   rdata = {{(BUS_W-NUM_EVT){1'b0}}, ien};
            OFF_FLAGS: rdata = {{(BUS_W-NUM_EVT){1'b0}}, flags};
            default:   rdata = '0;
        endcase
    end

    // R1: a halted channel keeps its count
    assert_halt_holds_R1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == $past(cnt)));

    // R4: an overflow step lands on zero
    assert_ovf_wraps_R4: assert property (@(posedge clk) disable iff (rst)
        (evt.ovf && !cnt_wr && !ext_clear) |=> (cnt == '0));

    // R5: clear on match A restarts from zero
    assert_clear_on_a_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl.clr == CLR_MATCH_A && cnt == cmp_a && !cnt_wr && !ext_clear)
        |=> (cnt == '0));

    // R6: a drive-high action on match A is visible next cycle
    assert_pin_high_on_a_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.match_a && act_a == ACT_HIGH && !oc_wr) |=> pin);

    // R7: every event leaves its flag set
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
        (|evt_bits) |=> ((flags & $past(evt_bits)) == $past(evt_bits)));

endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import tmr_pkg::*;
#(
    parameter int PRE_LO      = 8,
    parameter int PRE_MID     = 64,
    parameter int PRE_HI      = 8192,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] ext_clk_in,
    input  logic [NUM_CH-1:0] ext_rst_in,
    output logic [NUM_CH-1:0] tmr_out,
    output logic [NUM_CH-1:0] irq_match_a,
    output logic [NUM_CH-1:0] irq_match_b,
    output logic [NUM_CH-1:0] irq_ovf,
    output logic              conv_trig
);
    logic stopped;
    logic run;
    logic tick_lo, tick_mid, tick_hi;

    tmr_evt_t           evt   [NUM_CH];
    tmr_evt_t           evt_q [NUM_CH];
    logic [BUS_W-1:0]   ch_rdata [NUM_CH];
    logic [NUM_CH-1:0]  chain_tick;

    assign run = !stopped;

    always_ff @(posedge clk) begin
        if (rst)                                  stopped <= 1'b1;
        else if (bus_wr && bus_addr == ADDR_STOP) stopped <= bus_wdata[0];
    end

    tmr_prescale #(
        .PRE_LO (PRE_LO),
        .PRE_MID(PRE_MID),
        .PRE_HI (PRE_HI)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .tick_lo (tick_lo),
        .tick_mid(tick_mid),
        .tick_hi (tick_hi)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic ext_now, ext_was, xrst_now, xrst_was;
        logic [NUM_EVT-1:0] irq_bits;
        logic sel;

        assign sel = (bus_addr[ADDR_W-1] == c[0]);

        if (c == 0) begin : g_hi_byte
            assign chain_tick[c] = evt[1].ovf;
        end else begin : g_match_cnt
            assign chain_tick[c] = evt_q[0].match_a;
        end

        tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
            .clk(clk), .rst(rst), .din(ext_clk_in[c]), .now(ext_now), .was(ext_was)
        );

        tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
            .clk(clk), .rst(rst), .din(ext_rst_in[c]), .now(xrst_now), .was(xrst_was)
        );

        tmr_channel u_chan (
            .clk       (clk),
            .rst       (rst),
            .run       (run),
            .tick_lo   (tick_lo),
            .tick_mid  (tick_mid),
            .tick_hi   (tick_hi),
            .ext_now   (ext_now),
            .ext_was   (ext_was),
            .xrst_now  (xrst_now),
            .xrst_was  (xrst_was),
            .chain_tick(chain_tick[c]),
            .wr_en     (bus_wr && run && sel),
            .rd_en     (bus_rd && run && sel),
            .off       (bus_addr[OFF_W-1:0]),
            .wdata     (bus_wdata),
            .rdata     (ch_rdata[c]),
            .evt       (evt[c]),
            .evt_q     (evt_q[c]),
            .pin       (tmr_out[c]),
            .irq       (irq_bits)
        );

        assign irq_match_a[c] = irq_bits[0];
        assign irq_match_b[c] = irq_bits[1];
        assign irq_ovf[c]     = irq_bits[2];
    end

    assign conv_trig = evt_q[0].match_a;

    always_comb begin
        if (bus_addr == ADDR_STOP) bus_rdata = {{(BUS_W-1){1'b0}}, stopped};
        else if (stopped)          bus_rdata = '0;
        else                       bus_rdata = ch_rdata[bus_addr[ADDR_W-1]];
    end

    // R9: each channel-0 match A is followed by a trigger pulse
    assert_trig_follows_R9: assert property (@(posedge clk) disable iff (rst)
        evt[0].match_a |=> conv_trig);

    // R1: a stopped block produces no events
    assert_no_evt_stopped_R1: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !(evt[0].match_a || evt[0].ovf || evt[1].match_a || evt[1].ovf));

endmodule

// File: tb/dual_timer_test.sv
module dual_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] ext_clk_in = '0;
    logic [1:0] ext_rst_in = '0;
    logic [1:0] tmr_out, irq_match_a, irq_match_b, irq_ovf;
    logic       conv_trig;

    int n_checks = 0;
    int n_fail   = 0;
    int trig_seen = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dual_timer #(.PRE_LO(8), .PRE_MID(64), .PRE_HI(512), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
        .ext_rst_in(ext_rst_in), .tmr_out(tmr_out), .irq_match_a(irq_match_a),
        .irq_match_b(irq_match_b), .irq_ovf(irq_ovf), .conv_trig(conv_trig)
    );

    always @(negedge clk) if (conv_trig) trig_seen++;

    localparam logic [2:0] O_CTRL = 3'd0, O_CNT = 3'd1, O_CMPA = 3'd2, O_CMPB = 3'd3,
                           O_OCTL = 3'd4, O_IEN = 3'd5, O_FLG = 3'd6;

    // {start, cmpa, cmpb, clr, act_a, act_b, pulses, exp_cnt, exp_pin, exp_flags}
    localparam int NVEC = 6;
    localparam logic [49:0] VEC [NVEC] = '{
        {8'h00, 8'h03, 8'h05, 2'd0, 2'd2, 2'd1, 8'd4, 8'h04, 1'b1, 3'b001},
        {8'h00, 8'h03, 8'h05, 2'd0, 2'd2, 2'd1, 8'd6, 8'h06, 1'b0, 3'b011},
        {8'h00, 8'h02, 8'h09, 2'd1, 2'd3, 2'd0, 8'd7, 8'h01, 1'b0, 3'b001},
        {8'hFD, 8'hFE, 8'h01, 2'd0, 2'd2, 2'd1, 8'd4, 8'h01, 1'b0, 3'b111},
        {8'h00, 8'h02, 8'h02, 2'd0, 2'd2, 2'd1, 8'd2, 8'h02, 1'b1, 3'b011},
        {8'h00, 8'h07, 8'h03, 2'd2, 2'd0, 2'd3, 8'd5, 8'h01, 1'b1, 3'b010}
    };

    function automatic logic [3:0] ra(input int ch, input logic [2:0] o);
        return {ch[0], o};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int ch);
        ext_clk_in[ch] = 1'b1;
        repeat (3) @(negedge clk);
        ext_clk_in[ch] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulses(input int ch, input int n);
        for (int k = 0; k < n; k++) pulse(ch);
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_flags(input int ch);
        logic [7:0] d;
        rd(ra(ch, O_FLG), d);
        wr(ra(ch, O_FLG), 8'h00);
    endtask

    task automatic measure(output int period);
        logic [7:0] prev;
        int n;
        bus_addr = ra(1, O_CNT);
        #1 prev = bus_rdata;
        n = 0;
        while (bus_rdata == prev && n < 2000) begin @(negedge clk); #1; n++; end
        prev = bus_rdata;
        period = 0;
        while (bus_rdata == prev && period < 2000) begin @(negedge clk); #1; period++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int per, t0;
        logic [49:0] v;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(4'h7, d);            check("R1 stop after reset", d, 1);
        rd(ra(0, O_CMPA), d);   check("R1 read while stopped", d, 0);
        check("R1 pins idle", tmr_out, 0);
        check("R8 irqs idle", {irq_match_a, irq_match_b, irq_ovf}, 0);
        check("R9 trig idle", conv_trig, 0);

        // R1: write ignored while stopped; R4 compare reset value
        wr(ra(0, O_CMPA), 8'h12);
        wr(4'h7, 8'h00);
        rd(4'h7, d);            check("R1 stop released", d, 0);
        rd(ra(0, O_CMPA), d);   check("R1 R4 compare ignored write", d, 8'hFF);

        // R4 R5 R6 R7 R12: vector table on channel 0, external rising clock
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            wr(ra(0, O_CTRL), 8'h00);
            wr(ra(0, O_CNT),  v[49:42]);
            wr(ra(0, O_CMPA), v[41:34]);
            wr(ra(0, O_CMPB), v[33:26]);
            wr(ra(0, O_OCTL), {4'b0000, v[21:20], v[23:22]});
            clear_flags(0);
            wr(ra(0, O_CTRL), {3'b000, v[25:24], 3'd4});
            pulses(0, int'(v[19:12]));
            rd(ra(0, O_CNT), d);  check($sformatf("R4 R5 count vec%0d", i), d, v[11:4]);
            check($sformatf("R6 pin vec%0d", i), tmr_out[0], v[3]);
            rd(ra(0, O_FLG), d);  check($sformatf("R7 flags vec%0d", i), d, v[2:0]);
        end

        // R7 R8: flag protocol and interrupt gating
        clear_flags(0);
        rd(ra(0, O_FLG), d);    check("R7 flags cleared", d, 0);
        wr(ra(0, O_IEN), 8'h02);
        pulses(0, 2);           // count 1 -> 3 hits compare B
        check("R8 irq b on", irq_match_b[0], 1);
        check("R8 irq a gated", irq_match_a[0], 0);
        wr(ra(0, O_FLG), 8'h00);
        bus_addr = ra(0, O_FLG); #1;
        check("R7 unread flag kept", bus_rdata, 2);
        @(negedge clk);
        clear_flags(0);
        check("R7 R8 irq after clear", irq_match_b[0], 0);

        // R9 R11: trigger pulses and match-count mode
        wr(ra(0, O_CTRL), 8'h00);
        wr(ra(0, O_CNT),  8'h00);
        wr(ra(0, O_CMPA), 8'h01);
        wr(ra(1, O_CTRL), 8'h00);
        wr(ra(1, O_CNT),  8'h00);
        wr(ra(1, O_CTRL), 8'h05);
        t0 = trig_seen;
        wr(ra(0, O_CTRL), {3'b000, 2'd1, 3'd4});
        pulses(0, 4);
        check("R9 trigger pulses", trig_seen - t0, 2);
        rd(ra(1, O_CNT), d);    check("R11 match count", d, 2);

        // R10: 16-bit cascade
        wr(ra(0, O_CTRL), 8'h00);
        wr(ra(1, O_CTRL), 8'h00);
        wr(ra(1, O_CNT),  8'hFE);
        wr(ra(0, O_CNT),  8'h12);
        wr(ra(0, O_CTRL), 8'h05);
        wr(ra(1, O_CTRL), 8'h04);
        pulses(1, 3);
        rd(ra(1, O_CNT), d);    check("R10 low byte", d, 8'h01);
        rd(ra(0, O_CNT), d);    check("R10 high byte", d, 8'h13);
        wr(ra(0, O_CTRL), 8'h00);

        // R3: both edges, then falling edge
        wr(ra(1, O_CTRL), 8'h00);
        wr(ra(1, O_CNT),  8'h00);
        wr(ra(1, O_CTRL), {1'b0, 2'd2, 2'd0, 3'd4});
        pulses(1, 2);
        rd(ra(1, O_CNT), d);    check("R3 both edges", d, 4);
        wr(ra(1, O_CTRL), 8'h00);
        wr(ra(1, O_CNT),  8'h00);
        wr(ra(1, O_CTRL), {1'b0, 2'd1, 2'd0, 3'd4});
        ext_clk_in[1] = 1'b1;
        repeat (6) @(negedge clk);
        rd(ra(1, O_CNT), d);    check("R3 falling ignores rise", d, 0);
        ext_clk_in[1] = 1'b0;
        repeat (6) @(negedge clk);
        rd(ra(1, O_CNT), d);    check("R3 falling counts", d, 1);

        // R5: external reset clear
        wr(ra(1, O_CTRL), {1'b0, 2'd0, 2'd3, 3'd4});
        pulses(1, 2);
        rd(ra(1, O_CNT), d);    check("R5 before ext reset", d, 3);
        ext_rst_in[1] = 1'b1;
        repeat (3) @(negedge clk);
        ext_rst_in[1] = 1'b0;
        repeat (4) @(negedge clk);
        rd(ra(1, O_CNT), d);    check("R5 ext reset clears", d, 0);

        // R1: stop freezes counting
        wr(ra(1, O_CTRL), 8'h04);
        wr(ra(1, O_CNT),  8'h05);
        wr(4'h7, 8'h01);
        pulses(1, 3);
        wr(4'h7, 8'h00);
        rd(ra(1, O_CNT), d);    check("R1 frozen while stopped", d, 5);
        pulses(1, 1);
        rd(ra(1, O_CNT), d);    check("R1 runs after release", d, 6);

        // R2: prescaled periods
        wr(ra(1, O_CTRL), 8'h01);
        measure(per);           check("R2 divide lo", per, 8);
        wr(ra(1, O_CTRL), 8'h02);
        measure(per);           check("R2 divide mid", per, 64);
        wr(ra(1, O_CTRL), 8'h03);
        measure(per);           check("R2 divide hi", per, 512);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule